// File: doc/BRIEF.md
# Circular Sample Capture Controller

This block records a stream of logic samples into an on-chip memory that it treats as a ring. Once armed, it writes every accepted sample word. When the write address passes the last word it returns to zero and overwrites the oldest data. A trigger pulse starts a post-trigger phase. After a programmed number of further words has been stored, writing stops and the block reports that the acquisition is complete. A host then pulls the stored words through a sequential read port, and they come out oldest first.

The sample bus is 16 bits wide. In full-width mode each accepted sample fills one memory word. In half-width mode only one byte lane is kept, either the low or the high eight channels. Two consecutive bytes are packed into each memory word, which doubles the capture depth. The mode and lane are taken when the block is armed. The address of the first post-trigger word is reported, so the host can place the trigger inside the record.

Top module: `cap_ring_capture`

## Requirements
- R1: In full-width mode (half_i low at arm), every cycle with sample_vld_i high while capture is active stores sample_i unchanged as one memory word.
- R2: In half-width mode, each accepted sample contributes one byte: bits 7:0 when upper_i is low at arm, bits 15:8 when it is high. Two successive bytes form one word, with the earlier byte in bits 7:0 and the later one in bits 15:8.
- R3: half_i and upper_i are sampled only in the cycle arm_i is high; changing them during a capture has no effect on the stored words.
- R4: Words are written at ascending addresses from zero. The address after DEPTH-1 is zero, and the oldest word is overwritten. wrapped_o goes high once the write address has passed DEPTH-1 and stays high until the next arm.
- R5: After the trigger, exactly post_cnt_i (sampled with the trigger) further words are stored, then capture stops. A count of zero stops capture at the trigger cycle. Samples after the stop are ignored, and an incomplete half-width pair is discarded.
- R6: trig_pos_o is the address of the first word stored after the trigger cycle; a word written in the trigger cycle itself belongs to the pre-trigger record. trig_pos_o is zero after reset and after arm.
- R7: state_o reports 0 idle, 1 armed (waiting for trigger), 2 post-trigger, 3 complete; done_o is high exactly in state 3. Reset enters state 0.
- R8: Trigger pulses after the first one in an acquisition are ignored until the next arm.
- R9: A read request is accepted only in state 3 and only while unread words remain. One cycle after an accepted request, rd_vld_o is high and rd_data_o holds the next word in write order. The sequence starts at the oldest stored word, and rd_last_o marks the final one. The word count is DEPTH after a wrap and otherwise the number of words written.
- R10: arm_i restarts capture from any state. It clears the write address, the wrap flag, the trigger position and the read position, and enters state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a new acquisition |
| half_i | input | 1 | Half-width mode select, taken at arm |
| upper_i | input | 1 | Half-width lane select (1 = bits 15:8), taken at arm |
| sample_vld_i | input | 1 | Sample strobe |
| sample_i | input | 16 | Sample bus |
| trig_i | input | 1 | Trigger pulse |
| post_cnt_i | input | PCNT_W | Post-trigger word count |
| state_o | output | 2 | Acquisition state |
| done_o | output | 1 | Acquisition complete |
| wrapped_o | output | 1 | Ring has wrapped |
| trig_pos_o | output | AW | Address of first post-trigger word |
| rd_req_i | input | 1 | Read next word |
| rd_data_o | output | 16 | Read data |
| rd_vld_o | output | 1 | Read data valid |
| rd_last_o | output | 1 | Final word of the record |

## Verification
The bench builds the block with DEPTH = 16 and PCNT_W = 8. At that depth, a few dozen samples are enough to wrap the ring several times. Traces that stop before and after a wrap can then both be replayed in full. A trigger that lands at a wrap boundary, in the middle of a half-width byte pair, or with a zero post-trigger count can be reached in a few hundred cycles.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_lane_pack.sv
module cap_lane_pack #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              half_i,
  input  logic              upper_i,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int HALF_W = DATA_W / 2;

  logic              pend_q;
  logic [HALF_W-1:0] byte_q;
  logic [HALF_W-1:0] lane;

  assign lane = upper_i ? data_i[DATA_W-1:HALF_W] : data_i[HALF_W-1:0];

  always_comb begin
    wr_o   = en_i & vld_i & (~half_i | pend_q);
    word_o = half_i ? {lane, byte_q} : data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      byte_q <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (en_i && vld_i && half_i) begin
      pend_q <= ~pend_q;
      if (!pend_q) byte_q <= lane;
    end
  end
endmodule

// File: rtl/cap_ring_ctrl.sv
module cap_ring_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int PCNT_W = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic [PCNT_W-1:0] post_cnt_i,
  input  logic              wr_i,
  output cap_state_e        state_o,
  output logic              active_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic              wrapped_o,
  output logic [AW-1:0]     trig_pos_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e        state_q;
  logic [AW-1:0]     ptr_q, ptr_nxt;
  logic [PCNT_W-1:0] left_q;
  logic              wrap_q;
  logic [AW-1:0]     tpos_q;

  assign ptr_nxt = wr_i ? ((ptr_q == LAST) ? '0 : ptr_q + 1'b1) : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
      wrap_q  <= 1'b0;
      tpos_q  <= '0;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
      ptr_q   <= '0;
      left_q  <= '0;
      wrap_q  <= 1'b0;
      tpos_q  <= '0;
    end else if (state_q == ST_ARMED || state_q == ST_POST) begin
      ptr_q <= ptr_nxt;
      if (wr_i && ptr_q == LAST) wrap_q <= 1'b1;
      if (state_q == ST_ARMED) begin
        if (trig_i) begin
          tpos_q <= ptr_nxt;
          left_q <= post_cnt_i;
          state_q <= (post_cnt_i == '0) ? ST_DONE : ST_POST;
        end
      end else if (wr_i) begin
        left_q <= left_q - 1'b1;
        if (left_q == PCNT_W'(1)) state_q <= ST_DONE;
      end
    end
  end

  assign state_o    = state_q;
  assign active_o   = (state_q == ST_ARMED) || (state_q == ST_POST);
  assign wr_addr_o  = ptr_q;
  assign wrapped_o  = wrap_q;
  assign trig_pos_o = tpos_q;
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cap_readout.sv
module cap_readout #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          done_i,
  input  logic          wrapped_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          rd_req_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          rd_vld_o,
  output logic          rd_last_o
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [AW:0] idx_q, count, start, sum;
  logic        accept;

  // oldest word sits at the write address once the ring has wrapped
  assign count  = wrapped_i ? DEPTH_W : {1'b0, wr_addr_i};
  assign start  = wrapped_i ? {1'b0, wr_addr_i} : '0;
  assign sum    = start + idx_q;
  assign accept = done_i & rd_req_i & (idx_q < count);

  always_comb begin
    re_o    = accept;
    raddr_o = (sum >= DEPTH_W) ? AW'(sum - DEPTH_W) : AW'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      rd_vld_o  <= 1'b0;
      rd_last_o <= 1'b0;
    end else begin
      if (arm_i)       idx_q <= '0;
      else if (accept) idx_q <= idx_q + 1'b1;
      rd_vld_o  <= accept;
      rd_last_o <= accept && (idx_q == count - 1'b1);
    end
  end
endmodule

// File: rtl/cap_ring_capture.sv
module cap_ring_capture
  import cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int PCNT_W = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              half_i,
  input  logic              upper_i,
  input  logic              sample_vld_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              trig_i,
  input  logic [PCNT_W-1:0] post_cnt_i,
  output logic [1:0]        state_o,
  output logic              done_o,
  output logic              wrapped_o,
  output logic [AW-1:0]     trig_pos_o,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              rd_last_o
);
  cap_state_e        state;
  logic              half_q, upper_q, active, wr;
  logic [DATA_W-1:0] word;
  logic [AW-1:0]     wr_addr, raddr;
  logic              re;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      upper_q <= 1'b0;
    end else if (arm_i) begin
      half_q  <= half_i;
      upper_q <= upper_i;
    end
  end

  cap_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .half_i (half_q),
    .upper_i(upper_q),
    .en_i   (active),
    .vld_i  (sample_vld_i),
    .data_i (sample_i),
    .wr_o   (wr),
    .word_o (word)
  );

  cap_ring_ctrl #(.DEPTH(DEPTH), .PCNT_W(PCNT_W), .AW(AW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_i),
    .trig_i    (trig_i),
    .post_cnt_i(post_cnt_i),
    .wr_i      (wr),
    .state_o   (state),
    .active_o  (active),
    .wr_addr_o (wr_addr),
    .wrapped_o (wrapped_o),
    .trig_pos_o(trig_pos_o)
  );

  cap_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr),
    .waddr_i(wr_addr),
    .wdata_i(word),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  cap_readout #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .done_i   (done_o),
    .wrapped_i(wrapped_o),
    .wr_addr_i(wr_addr),
    .rd_req_i (rd_req_i),
    .re_o     (re),
    .raddr_o  (raddr),
    .rd_vld_o (rd_vld_o),
    .rd_last_o(rd_last_o)
  );

  assign state_o = state;
  assign done_o  = (state == ST_DONE);
endmodule

// File: rtl/cap_ring_capture_chk.sv
module cap_ring_capture_chk #(
  parameter int AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic          trig_i,
  input logic [1:0]    state_o,
  input logic          done_o,
  input logic          wrapped_o,
  input logic [AW-1:0] trig_pos_o,
  input logic          rd_vld_o,
  input logic          rd_last_o
);
  assert_done_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && !arm_i) |=> (state_o == 2'd3));

  assert_idle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !arm_i) |=> (state_o == 2'd0));

  assert_trig_pos_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1] && !arm_i) |=> $stable(trig_pos_o));

  assert_post_no_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && trig_i && !arm_i) |=> (state_o != 2'd1));

  assert_rd_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(done_o));

  assert_last_is_vld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_vld_o);

  assert_arm_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (state_o == 2'd1 && !wrapped_o && trig_pos_o == '0));
endmodule

bind cap_ring_capture cap_ring_capture_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .trig_i    (trig_i),
  .state_o   (state_o),
  .done_o    (done_o),
  .wrapped_o (wrapped_o),
  .trig_pos_o(trig_pos_o),
  .rd_vld_o  (rd_vld_o),
  .rd_last_o (rd_last_o)
);

// File: tb/cap_ring_capture_bench.sv
`timescale 1ns/1ps
module cap_ring_capture_bench;
  localparam int DEPTH  = 16;
  localparam int PCNT_W = 8;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              arm = 0, half = 0, upper = 0, vld = 0, trig = 0, rd_req = 0;
  logic [15:0]       sample = '0;
  logic [PCNT_W-1:0] post = '0;
  logic [1:0]        state_o;
  logic              done_o, wrapped_o, rd_vld_o, rd_last_o;
  logic [AW-1:0]     trig_pos_o;
  logic [15:0]       rd_data_o;

  cap_ring_capture #(.DATA_W(16), .DEPTH(DEPTH), .PCNT_W(PCNT_W)) u_cap_ring_capture (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .half_i(half), .upper_i(upper),
    .sample_vld_i(vld), .sample_i(sample), .trig_i(trig), .post_cnt_i(post),
    .state_o(state_o), .done_o(done_o), .wrapped_o(wrapped_o), .trig_pos_o(trig_pos_o),
    .rd_req_i(rd_req), .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .rd_last_o(rd_last_o)
  );

  int checks = 0, fails = 0;
  string scen = "R7";
  bit finished = 0;

  // reference model
  int          m_state, m_total, m_left, m_trigpos, m_ridx, m_old;
  bit          m_wrapped, m_pend, m_half, m_upper, m_w;
  logic [7:0]  m_pbyte, m_lane;
  logic [15:0] m_word;
  logic [15:0] hist[$];
  bit          e_vld, e_last;
  logic [15:0] e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_total = 0; m_left = 0; m_trigpos = 0; m_ridx = 0;
      m_wrapped = 0; m_pend = 0; m_half = 0; m_upper = 0; hist.delete();
      e_vld = 0; e_last = 0; e_data = '0;
    end else begin
      m_old = m_state; e_vld = 0; e_last = 0;
      if (arm) begin
        m_state = 1; hist.delete(); m_total = 0; m_pend = 0; m_half = half;
        m_upper = upper; m_trigpos = 0; m_ridx = 0; m_wrapped = 0;
      end else begin
        if (m_old == 3 && rd_req && m_ridx < hist.size()) begin
          e_vld = 1; e_data = hist[m_ridx]; e_last = (m_ridx == hist.size() - 1); m_ridx++;
        end
        if (m_old == 1 || m_old == 2) begin
          m_w = 0;
          if (vld) begin
            if (!m_half) begin m_w = 1; m_word = sample; end
            else begin
              m_lane = m_upper ? sample[15:8] : sample[7:0];
              if (!m_pend) begin m_pbyte = m_lane; m_pend = 1; end
              else begin m_w = 1; m_word = {m_lane, m_pbyte}; m_pend = 0; end
            end
          end
          if (m_w) begin
            hist.push_back(m_word);
            if (hist.size() > DEPTH) void'(hist.pop_front());
            m_total++;
            if (m_total >= DEPTH) m_wrapped = 1;
          end
          if (m_old == 1 && trig) begin
            m_trigpos = m_total % DEPTH;
            if (post == 0) m_state = 3;
            else begin m_left = post; m_state = 2; end
          end else if (m_old == 2 && m_w) begin
            m_left--;
            if (m_left == 0) m_state = 3;
          end
        end
      end
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s actual %0h expected %0h", rq, scen, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7", "state", state_o, m_state);
      chk("R7", "done", done_o, m_state == 3);
      chk("R4", "wrapped", wrapped_o, m_wrapped);
      chk("R6", "trig_pos", trig_pos_o, m_trigpos);
      chk("R9", "rd_vld", rd_vld_o, e_vld);
      if (e_vld) begin
        chk("R9", "rd_data", rd_data_o, e_data);
        chk("R9", "rd_last", rd_last_o, e_last);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm(input bit h, input bit u);
    half = h; upper = u; arm = 1; cyc(1); arm = 0;
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      vld = 1; sample = 16'($urandom);
      cyc(1);
      vld = 0;
      if (gaps && (i % 3 == 1)) cyc(1);
    end
  endtask

  task automatic fire(input int p, input bit with_sample);
    post = PCNT_W'(p); trig = 1; vld = with_sample; sample = 16'($urandom);
    cyc(1);
    trig = 0; vld = 0;
  endtask

  task automatic read_all(input int n);
    rd_req = 1; cyc(n); rd_req = 0; cyc(2);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired in scenario %s", scen);
    finish_run();
  end

  initial begin
    // reset state
    #1;
    chk("R7", "reset state", state_o, 0);
    chk("R7", "reset done", done_o, 0);
    chk("R9", "reset rd_vld", rd_vld_o, 0);
    cyc(3); rst_n = 1; cyc(2);
    rd_req = 1; cyc(3); rd_req = 0; cyc(1);

    // full width, trigger before wrap, trigger cycle carries a sample
    scen = "R1";
    do_arm(0, 0);
    feed(4, 1);
    scen = "R6";
    fire(3, 1);
    feed(3, 1);
    scen = "R5";
    feed(4, 0);
    read_all(11);

    // wrap several times, then stop
    scen = "R4";
    do_arm(0, 0);
    rd_req = 1; feed(40, 0); rd_req = 0;
    fire(5, 0);
    feed(12, 1);
    read_all(20);

    // zero post-trigger count
    scen = "R5";
    do_arm(0, 0);
    feed(3, 0);
    fire(0, 0);
    feed(5, 0);
    read_all(6);

    // empty record
    do_arm(0, 0);
    fire(0, 0);
    read_all(3);

    // half width, lower lane, with a second trigger
    scen = "R2";
    do_arm(1, 0);
    feed(37, 1);
    fire(4, 0);
    scen = "R8";
    feed(3, 0);
    fire(9, 1);
    feed(8, 0);
    scen = "R2";
    read_all(19);

    // half width upper lane; mode inputs move during capture, trigger mid-pair
    scen = "R3";
    do_arm(1, 1);
    half = 0; upper = 0;
    feed(51, 0);
    fire(3, 1);
    feed(10, 1);
    read_all(18);

    // re-arm during post-trigger phase
    scen = "R10";
    do_arm(0, 0);
    feed(20, 0);
    fire(6, 0);
    feed(2, 0);
    do_arm(1, 0);
    feed(9, 0);
    fire(2, 0);
    feed(6, 0);
    read_all(8);

    // re-arm after complete, mid-read
    rd_req = 1; cyc(2); rd_req = 0; cyc(1);
    do_arm(0, 1);
    feed(6, 0);
    fire(1, 0);
    feed(2, 0);
    read_all(9);

    finish_run();
  end
endmodule